// File: doc/BRIEF.md
# Bus and Peripheral Clock-Enable Prescaler Chain

This block turns the system clock into two clock-enable strobes. The first stage divides the system clock by a power of two taken from a 4-bit select field. Its strobe marks the bus clock edges. The second stage divides that bus strobe again, using a 3-bit select field. Its strobe marks the peripheral clock edges, so the peripheral rate is always a sub-multiple of the bus rate. Logic downstream qualifies its flops with these strobes in place of gated clocks.

Software can rewrite either select field at any time. A stage reads its field only on the last cycle of a division period. The period in progress therefore always runs to its full length, and no short or stretched strobe interval appears. Each stage reports the base-2 logarithm of the divisor it is currently using. A manager can read this to see when a new setting has taken hold.

Top module: `clkdiv_chain`

## Requirements
- R1: Bus-stage select codes 0000 to 0111 all mean divide by 1. Codes 1000, 1001, 1010, 1011, 1100, 1101, 1110 and 1111 mean divide by 2, 4, 8, 16, 64, 128, 256 and 512. The bus status output gives the log2 of the divisor in use: 0, 1, 2, 3, 4, 6, 7, 8 or 9.
- R2: Peripheral-stage select codes 000 to 011 mean divide by 1. Codes 100, 101, 110 and 111 mean divide by 2, 4, 8 and 16. The peripheral status output gives the log2 of the divisor in use, 0 to 4.
- R3: With a bus divisor D in force, `hclk_en_o` is high on exactly one system clock cycle in every D. With D = 1 it is high on every cycle.
- R4: The peripheral stage advances only on cycles where `hclk_en_o` is high. `pclk_en_o` is never high unless `hclk_en_o` is high. With bus divisor D and peripheral divisor P held steady, `pclk_en_o` pulses once every D*P system cycles.
- R5: The bus stage loads its select field only on a cycle where `hclk_en_o` is high, and the new divisor governs the very next period. The bus status changes only in the cycle after such a pulse.
- R6: The peripheral stage loads its select field only on a cycle where `pclk_en_o` is high, and the new divisor governs the very next period. The peripheral status changes only in the cycle after such a pulse.
- R7: In reset, and in the first cycle after reset is released, both status outputs read 0 and both strobes are high, whatever the select fields hold.
- R8: A select change that is reverted before the current period ends has no effect. The period that follows keeps the divisor that was sampled at its start.
- R9: The bus status never takes the value 5, meaning divide by 32, and never exceeds 9. The peripheral status never exceeds 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hdiv_sel_i | input | 4 | Bus-stage divisor select code |
| pdiv_sel_i | input | 3 | Peripheral-stage divisor select code |
| hclk_en_o | output | 1 | Bus clock-enable strobe |
| pclk_en_o | output | 1 | Peripheral clock-enable strobe |
| hdiv_log2_o | output | 4 | log2 of the bus divisor in force |
| pdiv_log2_o | output | 3 | log2 of the peripheral divisor in force |

## Verification
The assertions check these rules on every cycle:
- Status values change only right after a strobe.
- A status loaded after a strobe matches the code sampled on that strobe.
- The peripheral strobe implies the bus strobe.
- Divide by 1 gives a strobe on every cycle.
- The status never reaches a forbidden value.
- The reset state is correct.

The interval lengths themselves (D cycles for the bus, D*P for the peripheral) can only be shown by the bench. The bench times pulse-to-pulse gaps over a sweep of every select code. The same holds for the rules on mid-period reprogramming, including a change that is reverted before the period ends. These rely on counting whole periods.

// File: rtl/clkdiv_pkg.sv
// Package: shared constants for the prescaler chain.
// Assumes the bus field is 4 bits and the peripheral field is 3 bits.
package clkdiv_pkg;
    localparam int unsigned HSEL_W = 4;
    localparam int unsigned PSEL_W = 3;
    localparam int unsigned HLOG_W = 4;   // holds log2 values 0..9
    localparam int unsigned PLOG_W = 3;   // holds log2 values 0..4
    localparam int unsigned HLOG_MAX = 9;
    localparam int unsigned PLOG_MAX = 4;

    // Which code map a decoder instance implements
    typedef enum logic [0:0] {
        MAP_BUS  = 1'b0,
        MAP_PERI = 1'b1
    } map_kind_e;
endpackage

// File: rtl/clkdiv_code_map.sv
// Module: clkdiv_code_map
// Turns a divisor select code into the log2 of the divisor.
// The bus map skips log2 = 5 (divide by 32). The peripheral map tops out at log2 = 4.
// Assumes SEL_W = 4 for MAP_BUS and SEL_W = 3 for MAP_PERI.
module clkdiv_code_map
    import clkdiv_pkg::*;
#(
    parameter map_kind_e KIND  = MAP_BUS,
    parameter int unsigned SEL_W = 4,
    parameter int unsigned LOG_W = 4
) (
    input  logic [SEL_W-1:0] sel_i,
    output logic [LOG_W-1:0] log2_o
);
    localparam int unsigned IDX_W = SEL_W - 1;

    logic [IDX_W-1:0] idx;
    assign idx = sel_i[IDX_W-1:0];

    generate
        if (KIND == MAP_BUS) begin : g_bus
            // Purpose: map 0xxx to 0, and 1000..1111 to 1,2,3,4,6,7,8,9
            always_comb begin
                if (!sel_i[SEL_W-1]) begin
                    log2_o = '0;
                end else if (idx[IDX_W-1] == 1'b0) begin
                    log2_o = LOG_W'(idx) + LOG_W'(1);
                end else begin
                    log2_o = LOG_W'(idx) + LOG_W'(2);
                end
            end
        end else begin : g_peri
            // Purpose: map 0xx to 0, and 100..111 to 1,2,3,4
            always_comb begin
                if (!sel_i[SEL_W-1]) begin
                    log2_o = '0;
                end else begin
                    log2_o = LOG_W'(idx) + LOG_W'(1);
                end
            end
        end
    endgenerate
endmodule

// File: rtl/clkdiv_stage.sv
// Module: clkdiv_stage
// One power-of-two divider stage driven by an input tick.
// It counts ticks, and its strobe marks the last tick of each period.
// The next divisor is loaded only on that last tick, so a period is never cut short.
// Assumes the incoming log2 never exceeds CNT_W.
module clkdiv_stage #(
    parameter int unsigned CNT_W = 9,
    parameter int unsigned LOG_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [LOG_W-1:0] next_log2_i,
    output logic             en_o,
    output logic [LOG_W-1:0] log2_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [LOG_W-1:0] log2_q;
    logic [CNT_W:0]   span;
    logic [CNT_W:0]   last_idx;
    logic             at_end;

    // Purpose: work out the final count of the current period
    always_comb begin
        span     = {{CNT_W{1'b0}}, 1'b1} << log2_q;
        last_idx = span - {{CNT_W{1'b0}}, 1'b1};
        at_end   = ({1'b0, cnt_q} == last_idx);
    end

    assign en_o   = tick_i & at_end;
    assign log2_o = log2_q;

    // Purpose: count ticks, and on the last tick restart and load the new divisor
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            log2_q <= '0;
        end else if (tick_i) begin
            if (at_end) begin
                cnt_q  <= '0;
                log2_q <= next_log2_i;
            end else begin
                cnt_q  <= cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
            end
        end
    end
endmodule

// File: rtl/clkdiv_chain.sv
// Module: clkdiv_chain
// Two prescalers in series. The bus stage divides the system clock.
// The peripheral stage divides the bus strobe.
// Outputs are clock-enable strobes plus the log2 of each divisor in force.
// Assumes select fields may change at any time. A stage samples its field
// only at its own period end.
module clkdiv_chain
    import clkdiv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HSEL_W-1:0] hdiv_sel_i,
    input  logic [PSEL_W-1:0] pdiv_sel_i,
    output logic              hclk_en_o,
    output logic              pclk_en_o,
    output logic [HLOG_W-1:0] hdiv_log2_o,
    output logic [PLOG_W-1:0] pdiv_log2_o
);
    localparam int unsigned HCNT_W = HLOG_MAX;
    localparam int unsigned PCNT_W = PLOG_MAX;

    logic [HLOG_W-1:0] h_next_log2;
    logic [PLOG_W-1:0] p_next_log2;
    logic              h_en;

    clkdiv_code_map #(.KIND(MAP_BUS), .SEL_W(HSEL_W), .LOG_W(HLOG_W)) u_hmap (
        .sel_i  (hdiv_sel_i),
        .log2_o (h_next_log2)
    );

    clkdiv_code_map #(.KIND(MAP_PERI), .SEL_W(PSEL_W), .LOG_W(PLOG_W)) u_pmap (
        .sel_i  (pdiv_sel_i),
        .log2_o (p_next_log2)
    );

    clkdiv_stage #(.CNT_W(HCNT_W), .LOG_W(HLOG_W)) u_hstage (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (1'b1),
        .next_log2_i (h_next_log2),
        .en_o        (h_en),
        .log2_o      (hdiv_log2_o)
    );

    clkdiv_stage #(.CNT_W(PCNT_W), .LOG_W(PLOG_W)) u_pstage (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (h_en),
        .next_log2_i (p_next_log2),
        .en_o        (pclk_en_o),
        .log2_o      (pdiv_log2_o)
    );

    assign hclk_en_o = h_en;
endmodule

// File: rtl/clkdiv_chain_chk.sv
// Module: clkdiv_chain_chk
// Cycle-level properties of the prescaler chain, bound to the top module.
module clkdiv_chain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [3:0] hdiv_sel_i,
    input logic [2:0] pdiv_sel_i,
    input logic       hclk_en_o,
    input logic       pclk_en_o,
    input logic [3:0] hdiv_log2_o,
    input logic [2:0] pdiv_log2_o
);
    logic [3:0] h_want;
    logic [2:0] p_want;

    // Purpose: the expected log2 for each select code, built from the code tables
    always_comb begin
        case (hdiv_sel_i)
            4'b1000: h_want = 4'd1;
            4'b1001: h_want = 4'd2;
            4'b1010: h_want = 4'd3;
            4'b1011: h_want = 4'd4;
            4'b1100: h_want = 4'd6;
            4'b1101: h_want = 4'd7;
            4'b1110: h_want = 4'd8;
            4'b1111: h_want = 4'd9;
            default: h_want = 4'd0;
        endcase
        case (pdiv_sel_i)
            3'b100:  p_want = 3'd1;
            3'b101:  p_want = 3'd2;
            3'b110:  p_want = 3'd3;
            3'b111:  p_want = 3'd4;
            default: p_want = 3'd0;
        endcase
    end

    p_hload_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(hclk_en_o)) |-> (hdiv_log2_o == $past(h_want)));

    p_pload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(pclk_en_o)) |-> (pdiv_log2_o == $past(p_want)));

    p_div1_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (hdiv_log2_o == 4'd0) |-> hclk_en_o);

    p_peri_needs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pclk_en_o |-> hclk_en_o);

    p_hhold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hclk_en_o)) |-> $stable(hdiv_log2_o));

    p_phold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(pclk_en_o)) |-> $stable(pdiv_log2_o));

    p_reset_state_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (hdiv_log2_o == 4'd0 && pdiv_log2_o == 3'd0 && hclk_en_o && pclk_en_o));

    p_no_div32_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdiv_log2_o != 4'd5) && (hdiv_log2_o <= 4'd9));

    p_peri_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pdiv_log2_o <= 3'd4);
endmodule

bind clkdiv_chain clkdiv_chain_chk chk_i (.*);

// File: tb/clkdiv_chain_tb_top.sv
// Bench: sweeps every select code. It times the gaps between strobes and the
// status updates, and compares them with divisors computed from the code tables.
module clkdiv_chain_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYCLES = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] hsel = 4'b0000;
    logic [2:0] psel = 3'b000;
    logic       hen, pen;
    logic [3:0] hlog;
    logic [2:0] plog;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 0;

    // Monitor state
    int  cyc = 0;
    int  h_pulses = 0, p_pulses = 0;
    int  h_last = 0, p_last = 0;
    bit  h_valid = 0, p_valid = 0;
    int  h_rec_div = 1, p_rec_div = 1;
    int  h_rec_log = 0, p_rec_log = 0;
    bit  h_prev_pulse = 0, p_prev_pulse = 0;
    int  h_prev_log = 0, p_prev_log = 0;
    bit  h_chg = 0;
    int  h_gap = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_chain dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .hdiv_sel_i  (hsel),
        .pdiv_sel_i  (psel),
        .hclk_en_o   (hen),
        .pclk_en_o   (pen),
        .hdiv_log2_o (hlog),
        .pdiv_log2_o (plog)
    );

    function automatic int hlog_of(input logic [3:0] c);
        int k;
        if (!c[3]) return 0;
        k = int'(c[2:0]);
        return (k < 4) ? k + 1 : k + 2;
    endfunction

    function automatic int plog_of(input logic [2:0] c);
        if (!c[2]) return 0;
        return int'(c[1:0]) + 1;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Runs on every falling edge; checks status and strobe gaps
    always @(negedge clk) begin
        if (!rst_n) begin
            h_valid = 0; p_valid = 0; h_prev_pulse = 0; p_prev_pulse = 0;
            h_prev_log = 0; p_prev_log = 0;
        end else begin
            cyc++;
            if (h_prev_pulse) check(int'(hlog) == h_rec_log, "R1 bus status load", int'(hlog), h_rec_log);
            else              check(int'(hlog) == h_prev_log, "R5 bus status hold", int'(hlog), h_prev_log);
            if (p_prev_pulse) check(int'(plog) == p_rec_log, "R2 peri status load", int'(plog), p_rec_log);
            else              check(int'(plog) == p_prev_log, "R6 peri status hold", int'(plog), p_prev_log);
            if (hen) begin
                if (h_valid) begin
                    h_gap = cyc - h_last;
                    check(h_gap == h_rec_div, "R3 bus strobe gap", h_gap, h_rec_div);
                end
                h_last = cyc; h_valid = 1;
                h_rec_log = hlog_of(hsel);
                h_rec_div = 1 << h_rec_log;
                h_pulses++;
            end
            if (pen) begin
                check(hen == 1'b1, "R4 peri strobe without bus strobe", int'(hen), 1);
                if (p_valid && !h_chg)
                    check(cyc - p_last == p_rec_div, "R4 peri strobe gap", cyc - p_last, p_rec_div);
                p_last = cyc; p_valid = 1;
                p_rec_log = plog_of(psel);
                p_rec_div = (1 << hlog_of(hsel)) * (1 << p_rec_log);
                h_chg = 0;
                p_pulses++;
            end
            h_prev_pulse = hen; p_prev_pulse = pen;
            h_prev_log = int'(hlog); p_prev_log = int'(plog);
        end
    end

    task automatic set_h(input logic [3:0] c);
        @(posedge clk); #1;
        hsel = c;
        h_chg = 1;
    endtask

    task automatic set_p(input logic [2:0] c);
        @(posedge clk); #1;
        psel = c;
    endtask

    task automatic wait_h(input int n);
        int target;
        target = h_pulses + n;
        while (h_pulses < target) @(posedge clk);
    endtask

    task automatic wait_p(input int n);
        int target;
        target = p_pulses + n;
        while (p_pulses < target) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    // Ends a hung run as a failure
    initial begin
        repeat (WATCHDOG_CYCLES) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG_CYCLES, 0);
        finish_run();
    end

    initial begin
        // R7: reset state, with non-default fields applied during reset
        hsel = 4'b1111; psel = 3'b111;
        repeat (5) @(posedge clk);
        @(negedge clk);
        check(hen == 1'b1 && pen == 1'b1, "R7 strobes in reset", {30'd0, hen, pen}, 3);
        check(hlog == 4'd0 && plog == 3'd0, "R7 status in reset", int'(hlog) + int'(plog), 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(hen == 1'b1 && pen == 1'b1, "R7 strobes after release", {30'd0, hen, pen}, 3);
        check(hlog == 4'd0 && plog == 3'd0, "R7 status after release", int'(hlog) + int'(plog), 0);

        // R1, R3, R9: sweep every bus code with the peripheral stage at divide by 1
        set_p(3'b000);
        for (int c = 0; c < 16; c++) begin
            set_h(4'(c));
            wait_h(3);
            check(int'(hlog) == hlog_of(4'(c)), "R1 bus code sweep", int'(hlog), hlog_of(4'(c)));
            check(hlog != 4'd5, "R9 no divide by 32", int'(hlog), 4);
        end

        // R2, R4: every peripheral code over several bus divisors
        for (int hc = 7; hc < 11; hc++) begin
            set_h(4'(hc));
            wait_h(2);
            for (int pc = 0; pc < 8; pc++) begin
                set_p(3'(pc));
                wait_p(3);
                check(int'(plog) == plog_of(3'(pc)), "R2 peri code sweep", int'(plog), plog_of(3'(pc)));
            end
        end

        // R4: largest combined ratio, 512 * 16
        set_h(4'b1111);
        set_p(3'b111);
        wait_p(3);

        // R5: change mid-period; the current period keeps 512, the next uses 2
        set_p(3'b000);
        wait_h(2);
        repeat (20) @(posedge clk);
        set_h(4'b1000);
        wait_h(1);
        check(h_gap == 512, "R5 old divisor finishes period", h_gap, 512);
        wait_h(1);
        check(h_gap == 2, "R5 new divisor in next period", h_gap, 2);

        // R8: a change reverted before the period ends has no effect
        set_h(4'b1110);
        wait_h(2);
        repeat (30) @(posedge clk);
        set_h(4'b1001);
        repeat (10) @(posedge clk);
        set_h(4'b1110);
        wait_h(1);
        check(h_gap == 256, "R8 reverted change, current period", h_gap, 256);
        wait_h(1);
        check(h_gap == 256, "R8 reverted change, next period", h_gap, 256);
        check(int'(hlog) == 8, "R8 status unchanged", int'(hlog), 8);

        // R6: peripheral change mid-period takes hold only after the peripheral strobe
        set_h(4'b1000);
        set_p(3'b110);
        wait_p(2);
        repeat (3) @(posedge clk);
        set_p(3'b100);
        @(negedge clk);
        check(int'(plog) == 3, "R6 peri status before period end", int'(plog), 3);
        wait_p(2);
        check(int'(plog) == 1, "R6 peri status after period end", int'(plog), 1);

        repeat (5) @(posedge clk);
        finish_run();
    end
endmodule